// File: doc/BRIEF.md
# Accumulator Rotate and Decimal Adjust Unit

This unit carries out the operations of a classic 8-bit processor that work on the accumulator alone. They are the four single-bit rotates, complementing the accumulator, setting carry, inverting carry, and decimal adjust after a packed-BCD addition. A 3-bit select picks the operation. The unit takes in the accumulator, the carry and auxiliary carry flags, and the current sign, zero and parity flags. It returns the new accumulator and a full set of new flags. Flags that an operation does not touch pass through unchanged, so the caller can write back all flags on every result.

Operations enter through a valid/ready request port and leave through a valid/ready result port, with one register stage between them. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. While `out_valid` is high and `out_ready` is low, the result and its flags are held stable and `in_ready` is low, so back-pressure passes straight through to the requester. `in_ready` is high whenever the output register is empty or being emptied in the same cycle, which allows one operation per cycle when there is no back-pressure.

Top module: `acc_misc_unit`

## Requirements
- R1: Select 0 (rotate left, carry copy): the result is the accumulator shifted left one place with old bit 7 placed in bit 0, and carry becomes old bit 7.
- R2: Select 1 (rotate right, carry copy): the result is the accumulator shifted right one place with old bit 0 placed in bit 7, and carry becomes old bit 0.
- R3: Select 2 (rotate left through carry): the result is the accumulator shifted left with the old carry in bit 0, and carry becomes old bit 7.
- R4: Select 3 (rotate right through carry): the result is the accumulator shifted right with the old carry in bit 7, and carry becomes old bit 0.
- R5: Select 4 inverts all eight accumulator bits and keeps carry. Select 5 forces carry to 1 and select 6 inverts carry; both of these keep the accumulator.
- R6: Selects 0 to 6 return the sign, zero, parity and auxiliary carry inputs unchanged.
- R7: Select 7 (decimal adjust) adds 6 when the low nibble is above 9 or auxiliary carry is set. Auxiliary carry becomes the carry out of bit 3 from that addition, and 0 when no low correction is made.
- R8: Select 7 then adds 0x60 when the bits above bit 3 of the intermediate 9-bit value exceed 9 or carry is set. Carry becomes 1 if it was set or if the final 9-bit sum passes 0xFF; a set carry is never cleared.
- R9: Select 7 sets sign to result bit 7, zero when the result is 0x00, and parity to 1 when the result has an even number of one bits.
- R10: A request accepted on a clock edge gives `out_valid` high after that edge. While `out_ready` is low, `out_valid` and all result outputs stay unchanged.
- R11: After reset `out_valid` is low. `in_ready` equals (not `out_valid`) or `out_ready`, and `out_valid` drops after a handshake with no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | Operation select (0 to 7) |
| in_acc | input | 8 | Accumulator operand |
| in_cy | input | 1 | Carry flag in |
| in_ac | input | 1 | Auxiliary carry flag in |
| in_sign | input | 1 | Sign flag in |
| in_zero | input | 1 | Zero flag in |
| in_parity | input | 1 | Parity flag in |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 8 | New accumulator |
| out_cy | output | 1 | New carry |
| out_ac | output | 1 | New auxiliary carry |
| out_sign | output | 1 | New sign |
| out_zero | output | 1 | New zero |
| out_parity | output | 1 | New parity (1 = even) |

## Verification
The hardest cases to reach are the decimal adjust inputs where the low-nibble correction pushes the value past 0xFF. In these cases the high correction is triggered only by bit 8 of the intermediate value, and carry must come out set although the accumulator looks small. The stimulus covers them with directed operands such as 0xFA and 0xFF, with and without the incoming flags. Random operands over all eight selects, with random incoming flags, cover the rest. A held-output phase keeps `out_ready` low for several cycles while a second request waits, which checks that the result is held and that no request is lost.

// File: rtl/acc_misc_pkg.sv
package acc_misc_pkg;
  localparam int ACC_W = 8;
  localparam int NIB_W = ACC_W / 2;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ROL_COPY = 3'd0,
    OP_ROR_COPY = 3'd1,
    OP_ROL_THRU = 3'd2,
    OP_ROR_THRU = 3'd3,
    OP_INVERT   = 3'd4,
    OP_SET_CY   = 3'd5,
    OP_FLIP_CY  = 3'd6,
    OP_DEC_ADJ  = 3'd7
  } accop_e;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             cy;
    logic             ac;
    logic             sign;
    logic             zero;
    logic             parity;
  } acc_res_t;
endpackage

// File: rtl/acc_shift_logic.sv
module acc_shift_logic
  import acc_misc_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  accop_e       op,
  input  logic [W-1:0] a,
  input  logic         cy_in,
  output logic [W-1:0] a_out,
  output logic         cy_out
);
  localparam int MSB = W - 1;

  always_comb begin
    a_out  = a;
    cy_out = cy_in;
    unique case (op)
      OP_ROL_COPY: begin a_out = {a[MSB-1:0], a[MSB]}; cy_out = a[MSB]; end
      OP_ROR_COPY: begin a_out = {a[0], a[MSB:1]};     cy_out = a[0];   end
      OP_ROL_THRU: begin a_out = {a[MSB-1:0], cy_in};  cy_out = a[MSB]; end
      OP_ROR_THRU: begin a_out = {cy_in, a[MSB:1]};    cy_out = a[0];   end
      OP_INVERT:   a_out  = ~a;
      OP_SET_CY:   cy_out = 1'b1;
      OP_FLIP_CY:  cy_out = ~cy_in;
      default:     ;
    endcase
  end

  // R1 / R2: rotates with carry copy keep the number of one bits
  always_comb begin
    if (!$isunknown({op, a}) && (op == OP_ROL_COPY || op == OP_ROR_COPY))
      a_r1_ones_kept: assert ($countones(a_out) == $countones(a));
  end
endmodule

// File: rtl/acc_decimal_fix.sv
module acc_decimal_fix
  import acc_misc_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] a_out,
  output logic         cy_out,
  output logic         ac_out
);
  localparam int NW = W / 2;
  localparam logic [W:0] LO_FIX = (W+1)'(6);
  localparam logic [W:0] HI_FIX = (W+1)'(6) << NW;

  logic          lo_need, hi_need;
  logic [NW:0]   lo_sum;
  logic [W:0]    mid, fin;
  logic [W-NW:0] mid_hi;

  always_comb begin
    lo_need = (a[NW-1:0] > NW'(9)) || ac_in;
    lo_sum  = {1'b0, a[NW-1:0]} + (NW+1)'(6);
    mid     = {1'b0, a} + (lo_need ? LO_FIX : '0);
    mid_hi  = mid[W:NW];
    hi_need = (mid_hi > (W-NW+1)'(9)) || cy_in;
    fin     = mid + (hi_need ? HI_FIX : '0);
    a_out   = fin[W-1:0];
    cy_out  = cy_in | fin[W];
    ac_out  = lo_need & lo_sum[NW];
  end

  // R8: an incoming carry is never cleared by the adjustment
  always_comb begin
    if (!$isunknown({cy_in, cy_out}) && cy_in)
      a_r8_carry_sticky: assert (cy_out);
  end
  // R7: no low correction means no auxiliary carry
  always_comb begin
    if (!$isunknown({a, ac_in}) && (a[NW-1:0] < NW'(10)) && !ac_in)
      a_r7_no_aux: assert (!ac_out);
  end
endmodule

// File: rtl/acc_flag_calc.sv
module acc_flag_calc #(
  parameter int W = 8
) (
  input  logic [W-1:0] v,
  output logic         sign,
  output logic         zero,
  output logic         parity
);
  always_comb begin
    sign   = v[W-1];
    zero   = (v == '0);
    parity = ~(^v);
  end
endmodule

// File: rtl/acc_misc_unit.sv
module acc_misc_unit
  import acc_misc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [ACC_W-1:0] in_acc,
  input  logic             in_cy,
  input  logic             in_ac,
  input  logic             in_sign,
  input  logic             in_zero,
  input  logic             in_parity,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_acc,
  output logic             out_cy,
  output logic             out_ac,
  output logic             out_sign,
  output logic             out_zero,
  output logic             out_parity
);
  accop_e           op;
  logic [ACC_W-1:0] sh_acc, da_acc;
  logic             sh_cy, da_cy, da_ac;
  logic             da_s, da_z, da_p;
  acc_res_t         nxt, held;
  logic             take;

  assign op = accop_e'(in_op);

  acc_shift_logic #(.W(ACC_W)) u_shift (
    .op(op), .a(in_acc), .cy_in(in_cy), .a_out(sh_acc), .cy_out(sh_cy)
  );

  acc_decimal_fix #(.W(ACC_W)) u_dec (
    .a(in_acc), .cy_in(in_cy), .ac_in(in_ac),
    .a_out(da_acc), .cy_out(da_cy), .ac_out(da_ac)
  );

  acc_flag_calc #(.W(ACC_W)) u_flags (
    .v(da_acc), .sign(da_s), .zero(da_z), .parity(da_p)
  );

  always_comb begin
    if (op == OP_DEC_ADJ) begin
      nxt = '{acc: da_acc, cy: da_cy, ac: da_ac, sign: da_s, zero: da_z, parity: da_p};
    end else begin
      nxt = '{acc: sh_acc, cy: sh_cy, ac: in_ac, sign: in_sign, zero: in_zero, parity: in_parity};
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     held      <= nxt;
    end
  end

  assign out_acc    = held.acc;
  assign out_cy     = held.cy;
  assign out_ac     = held.ac;
  assign out_sign   = held.sign;
  assign out_zero   = held.zero;
  assign out_parity = held.parity;

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_cy)
      && $stable(out_ac) && $stable(out_sign) && $stable(out_zero) && $stable(out_parity));
  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  a_r6_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    take && op != OP_DEC_ADJ |=> out_sign == $past(in_sign) && out_zero == $past(in_zero)
      && out_parity == $past(in_parity) && out_ac == $past(in_ac));
endmodule

// File: tb/sim_acc_misc_unit.sv
module sim_acc_misc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_op = '0;
  logic [7:0] in_acc = '0;
  logic in_cy = 0, in_ac = 0, in_sign = 0, in_zero = 0, in_parity = 0;
  logic in_ready, out_valid, out_cy, out_ac, out_sign, out_zero, out_parity;
  logic [7:0] out_acc;
  int n_chk = 0, n_bad = 0;
  logic [12:0] exp_v;

  always #5 clk = ~clk;

  acc_misc_unit u0 (.*);

  function automatic logic [12:0] model(input int op, input logic [7:0] a,
      input logic c, input logic h, input logic s, input logic z, input logic p);
    int v, lo; logic [7:0] r; logic nc, nh, ns, nz, np; int ones;
    r = a; nc = c; nh = h; ns = s; nz = z; np = p;
    case (op)
      0: begin r = (a << 1) | (a >> 7); nc = a[7]; end
      1: begin r = (a >> 1) | (a << 7); nc = a[0]; end
      2: begin r = (a << 1) | 8'(c);    nc = a[7]; end
      3: begin r = (a >> 1) | (8'(c) << 7); nc = a[0]; end
      4: r = 8'hFF - a;
      5: nc = 1;
      6: nc = !c;
      default: begin
        v = a; lo = a % 16; nh = 0;
        if (lo > 9 || h) begin v = v + 6; nh = (lo + 6) >= 16; end
        if ((v / 16) > 9 || c) v = v + 96;
        nc = c || (v > 255);
        r = 8'(v % 256);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        ns = r >= 8'h80; nz = (r == 0); np = (ones % 2) == 0;
      end
    endcase
    return {r, nc, nh, ns, nz, np};
  endfunction

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4, 5, 6: return "R5 R6"; default: return "R7 R8 R9";
    endcase
  endfunction

  task automatic run_op(input int op, input logic [7:0] a, input logic [4:0] f);
    @(negedge clk);
    in_op = 3'(op); in_acc = a;
    {in_cy, in_ac, in_sign, in_zero, in_parity} = f;
    in_valid = 1; out_ready = 1;
    exp_v = model(op, a, f[4], f[3], f[2], f[1], f[0]);
    @(negedge clk);
    in_valid = 0;
    check({tag_of(op), " R10 valid"}, {12'd0, out_valid}, 13'd1);
    check(tag_of(op), {out_acc, out_cy, out_ac, out_sign, out_zero, out_parity}, exp_v);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset valid", {12'd0, out_valid}, 13'd0);
    check("R11 reset ready", {12'd0, in_ready}, 13'd1);
    rst_n = 1;
    @(negedge clk);
    // directed corner cases
    run_op(0, 8'h81, 5'b00000);
    run_op(1, 8'h01, 5'b10000);
    run_op(2, 8'h80, 5'b00000);
    run_op(2, 8'h00, 5'b10000);
    run_op(3, 8'h01, 5'b10000);
    run_op(4, 8'h5A, 5'b11111);
    run_op(5, 8'h33, 5'b00000);
    run_op(6, 8'h33, 5'b10101);
    run_op(7, 8'h9B, 5'b00000);
    run_op(7, 8'hFA, 5'b00000);
    run_op(7, 8'hFF, 5'b11000);
    run_op(7, 8'h00, 5'b00000);
    run_op(7, 8'h12, 5'b01000);
    run_op(7, 8'h45, 5'b10000);
    // R11 drain after handshake with no new request
    @(negedge clk);
    check("R11 drain", {12'd0, out_valid}, 13'd0);
    // R10 back-pressure hold
    @(negedge clk);
    in_op = 3'd4; in_acc = 8'h0F; {in_cy, in_ac, in_sign, in_zero, in_parity} = 5'b0;
    in_valid = 1; out_ready = 0;
    snap = model(4, 8'h0F, 0, 0, 0, 0, 0);
    @(negedge clk);
    in_op = 3'd5; in_acc = 8'hAA;
    for (int k = 0; k < 4; k++) begin
      check("R10 held data", {out_acc, out_cy, out_ac, out_sign, out_zero, out_parity}, snap);
      check("R11 ready low", {11'd0, out_valid, in_ready}, 13'b10);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 second after release", {out_acc, out_cy, out_ac, out_sign, out_zero, out_parity},
          model(5, 8'hAA, 0, 0, 0, 0, 0));
    // random
    for (int i = 0; i < 400; i++) begin
      run_op(int'($urandom_range(0, 7)), 8'($urandom), 5'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule